// File: doc/BRIEF.md
# Flash Command Interface State Machine

This block is the command front end of a byte-wide parallel NOR-style flash. The host talks to it through active-low chip-enable, output-enable and write-enable strobes, an address bus and a byte data path, plus a flag that says whether the high programming supply is present. Every write cycle hands one byte to a command decoder. The block returns array bytes, the two identifier codes, or a status byte while an operation runs.

Any change to the array takes two writes: a set-up command, then a confirming write. A byte program is armed with one write, and the next write carries the address and data. A chip erase and a block erase each take a set-up byte and a confirm byte. An erase first sweeps its range to zero, then waits out a margin countdown, then sweeps the range to FFh. While an operation is running, a read returns status instead of array data. Bit 7 of the status is the complement of the programmed data's bit 7, or 0 during an erase. Bit 6 flips at the start of every read cycle.

The array is a small block-RAM-style memory inside the block. It starts at all FFh. Program and erase run for a number of cycles set by parameters. The strobes are sampled on the system clock.

Top module: `flash_cmd_if`

## Requirements
- R1: After reset the block is in array-read mode. Every location reads FFh. `dq_oe` is 0 until a read cycle (`ce_n`=0, `oe_n`=0, `we_n`=1) is in progress.
- R2: While `vpp_hi` is 0, the mode is forced back to array read within one clock. Writes have no effect on the mode or on the array.
- R3: Writing 00h selects array read. Array read stays selected across any number of reads until another command is written.
- R4: Writing 90h selects identifier read. Reads with address bit 0 clear return C2h, and reads with it set return 3Ch. The other address bits are ignored.
- R5: Writing 40h and then a write of address A and data D (D not FFh) replaces the byte at A with (old AND D) after `PGM_CYCLES` clocks. The block then returns to array read.
- R6: During a program, a read returns a status byte. Bit 7 is NOT D[7]. Bit 6 is inverted from one read cycle to the next. Bits 5..0 are 0.
- R7: Writing 30h twice erases the whole array to FFh. During the erase, reads return a status byte whose bit 7 and bits 5..0 are 0.
- R8: Writing 20h and then D0h at address A erases to FFh only the block of 2^`BLK_AW` bytes that holds A. The block index is A >> `BLK_AW`. All other bytes are unchanged.
- R9: A write of FFh right after any set-up command (40h, 30h or 20h), followed by a second FFh, aborts the sequence. Memory is unchanged and the block is back in array read.
- R10: After the 30h or 20h set-up, a second write that is neither the matching confirm nor FFh returns the block to array read. Memory is unchanged.
- R11: For a write cycle, the address is the one present when both `ce_n` and `we_n` first become low. The data is the one present in the last clock before either of them rises.
- R12: Writes issued while a program or erase is running are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| vpp_hi | input | 1 | Programming supply present; 0 allows array reads only |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Byte address |
| dq_i | input | 8 | Data from the host during write cycles |
| dq_o | output | 8 | Read data, identifier code or status |
| dq_oe | output | 1 | Drive enable for `dq_o` onto the shared byte bus |

## Verification
A read cycle can start in the same clock in which a program finishes. That clock must decide between the status byte and the array byte. The bench programs fresh bytes and, for each one, starts a read cycle at a different offset around the expected completion clock, sweeping across it. It holds each read long enough for the operation to finish and expects the final sample to equal the ANDed byte its own model computes, with no status pattern left behind. A second overlap, where `vpp_hi` drops while identifier mode is active, is judged by requiring that the next read return array data.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [2:0] {
    M_READ,
    M_IDENT,
    M_PGM_ARM,
    M_CHIP_ARM,
    M_BLK_ARM,
    M_ABORT,
    M_PGM_RUN,
    M_ERS_RUN
  } mode_t;

  typedef enum logic [1:0] {
    E_PRE,
    E_WAIT,
    E_POST
  } ers_phase_t;

  localparam logic [7:0] CMD_READ   = 8'h00;
  localparam logic [7:0] CMD_IDENT  = 8'h90;
  localparam logic [7:0] CMD_PGM    = 8'h40;
  localparam logic [7:0] CMD_CHIP   = 8'h30;
  localparam logic [7:0] CMD_BLK    = 8'h20;
  localparam logic [7:0] CMD_BLK_GO = 8'hD0;
  localparam logic [7:0] CMD_ABORT  = 8'hFF;

  localparam logic [7:0] ID_MAKER   = 8'hC2;
  localparam logic [7:0] ID_PART    = 8'h3C;

endpackage

// File: rtl/fci_bus_sync.sv
// Samples the host strobes and forms write and read cycle events.
module fci_bus_sync #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        dq_i,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              rd_live,
  output logic              rd_first
);

  logic              wr_act;
  logic              rd_act;
  logic              wr_q;
  logic [ADDR_W-1:0] addr_lat;
  logic [7:0]        data_lat;

  assign wr_act = !ce_n && !we_n;
  assign rd_act = !ce_n && !oe_n && we_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q     <= 1'b0;
      wr_stb   <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      addr_lat <= '0;
      data_lat <= '0;
      rd_live  <= 1'b0;
      rd_first <= 1'b0;
    end else begin
      wr_q     <= wr_act;
      rd_live  <= rd_act;
      rd_first <= rd_act && !rd_live;
      // address: first clock in which both strobes are low
      if (wr_act && !wr_q) addr_lat <= addr;
      // data: keeps the value of the last clock before release
      if (wr_act) data_lat <= dq_i;
      wr_stb <= !wr_act && wr_q;
      if (!wr_act && wr_q) begin
        wr_addr <= addr_lat;
        wr_data <= data_lat;
      end
    end
  end

endmodule

// File: rtl/fci_array.sv
// Single-port byte array, read registered, written to infer block RAM.
module fci_array #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] a,
  input  logic [7:0]        wd,
  output logic [7:0]        q
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = 8'hFF;
  end

  always_ff @(posedge clk) begin
    if (we) mem[a] <= wd;
    q <= mem[a];
  end

endmodule

// File: rtl/fci_seq.sv
// Command decoder plus the program and erase engines.
module fci_seq
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int BLK_AW     = 4,
  parameter int PGM_CYCLES = 24,
  parameter int ERS_WAIT   = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vpp_hi,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [7:0]        mem_q,
  output mode_t             mode,
  output logic              busy,
  output logic              erasing,
  output logic              pgm_msb,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wd
);

  localparam int MAXC = (PGM_CYCLES > ERS_WAIT) ? PGM_CYCLES : ERS_WAIT;
  localparam int CW   = $clog2(MAXC + 1);
  localparam int BW   = ADDR_W - BLK_AW;

  mode_t             st;
  ers_phase_t        ph;
  logic [CW-1:0]     cnt;
  logic [ADDR_W-1:0] ptr;
  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] last;
  logic [ADDR_W-1:0] pg_addr;
  logic [7:0]        pg_data;
  logic [BW-1:0]     blk_sel;

  assign blk_sel = wr_addr[ADDR_W-1:BLK_AW];

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= M_READ;
      ph      <= E_PRE;
      cnt     <= '0;
      ptr     <= '0;
      base    <= '0;
      last    <= '0;
      pg_addr <= '0;
      pg_data <= 8'hFF;
    end else if (!vpp_hi) begin
      st <= M_READ;
    end else begin
      case (st)
        M_PGM_RUN: begin
          if (cnt == '0) st <= M_READ;
          else cnt <= cnt - 1'b1;
        end
        M_ERS_RUN: begin
          case (ph)
            E_PRE: begin
              if (ptr == last) begin
                ph  <= E_WAIT;
                cnt <= CW'(ERS_WAIT - 1);
                ptr <= base;
              end else begin
                ptr <= ptr + 1'b1;
              end
            end
            E_WAIT: begin
              if (cnt == '0) ph <= E_POST;
              else cnt <= cnt - 1'b1;
            end
            default: begin
              if (ptr == last) st <= M_READ;
              else ptr <= ptr + 1'b1;
            end
          endcase
        end
        M_PGM_ARM: begin
          if (wr_stb) begin
            if (wr_data == CMD_ABORT) begin
              st <= M_ABORT;
            end else begin
              st      <= M_PGM_RUN;
              pg_addr <= wr_addr;
              pg_data <= wr_data;
              cnt     <= CW'(PGM_CYCLES - 1);
            end
          end
        end
        M_CHIP_ARM: begin
          if (wr_stb) begin
            if (wr_data == CMD_CHIP) begin
              st   <= M_ERS_RUN;
              ph   <= E_PRE;
              base <= '0;
              ptr  <= '0;
              last <= '1;
            end else if (wr_data == CMD_ABORT) begin
              st <= M_ABORT;
            end else begin
              st <= M_READ;
            end
          end
        end
        M_BLK_ARM: begin
          if (wr_stb) begin
            if (wr_data == CMD_BLK_GO) begin
              st   <= M_ERS_RUN;
              ph   <= E_PRE;
              base <= {blk_sel, {BLK_AW{1'b0}}};
              ptr  <= {blk_sel, {BLK_AW{1'b0}}};
              last <= {blk_sel, {BLK_AW{1'b1}}};
            end else if (wr_data == CMD_ABORT) begin
              st <= M_ABORT;
            end else begin
              st <= M_READ;
            end
          end
        end
        M_ABORT: begin
          if (wr_stb) st <= M_READ;
        end
        default: begin
          if (wr_stb) begin
            case (wr_data)
              CMD_IDENT: st <= M_IDENT;
              CMD_PGM:   st <= M_PGM_ARM;
              CMD_CHIP:  st <= M_CHIP_ARM;
              CMD_BLK:   st <= M_BLK_ARM;
              default:   st <= M_READ;
            endcase
          end
        end
      endcase
    end
  end

  always_comb begin
    busy    = (st == M_PGM_RUN) || (st == M_ERS_RUN);
    erasing = (st == M_ERS_RUN);
    pgm_msb = pg_data[7];
    mode    = st;
    mem_we  = vpp_hi && (((st == M_PGM_RUN) && (cnt == '0)) ||
                         ((st == M_ERS_RUN) && (ph != E_WAIT)));
    if (st == M_PGM_RUN)      mem_addr = pg_addr;
    else if (st == M_ERS_RUN) mem_addr = ptr;
    else                      mem_addr = host_addr;
    if (st == M_PGM_RUN)      mem_wd = mem_q & pg_data;
    else if (ph == E_PRE)     mem_wd = 8'h00;
    else                      mem_wd = 8'hFF;
  end

endmodule

// File: rtl/fci_readmux.sv
// Registered read path: array byte, identifier code or status byte.
module fci_readmux
  import flash_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       rd_live,
  input  logic       rd_first,
  input  mode_t      mode,
  input  logic       busy,
  input  logic       erasing,
  input  logic       pgm_msb,
  input  logic       id_sel,
  input  logic [7:0] mem_q,
  output logic [7:0] dq_o,
  output logic       dq_oe,
  output logic       tgl
);

  logic tgl_n;

  assign tgl_n = tgl ^ (busy && rd_first);

  always_ff @(posedge clk) begin
    if (rst) begin
      tgl   <= 1'b0;
      dq_o  <= '0;
      dq_oe <= 1'b0;
    end else begin
      tgl   <= tgl_n;
      dq_oe <= rd_live;
      if (rd_live) begin
        if (busy)                 dq_o <= {erasing ? 1'b0 : !pgm_msb, tgl_n, 6'b0};
        else if (mode == M_IDENT) dq_o <= id_sel ? ID_PART : ID_MAKER;
        else                      dq_o <= mem_q;
      end
    end
  end

endmodule

// File: rtl/flash_cmd_if.sv
module flash_cmd_if
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int BLK_AW     = 4,
  parameter int PGM_CYCLES = 24,
  parameter int ERS_WAIT   = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vpp_hi,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        dq_i,
  output logic [7:0]        dq_o,
  output logic              dq_oe
);

  logic              wr_stb;
  logic [ADDR_W-1:0] wr_addr;
  logic [7:0]        wr_data;
  logic              rd_live;
  logic              rd_first;
  mode_t             mode;
  logic              busy;
  logic              erasing;
  logic              pgm_msb;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [7:0]        mem_wd;
  logic [7:0]        mem_q;
  logic              tgl;

  fci_bus_sync #(.ADDR_W(ADDR_W)) u_bus (
    .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .dq_i(dq_i), .wr_stb(wr_stb), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_live(rd_live), .rd_first(rd_first)
  );

  fci_seq #(
    .ADDR_W(ADDR_W), .BLK_AW(BLK_AW),
    .PGM_CYCLES(PGM_CYCLES), .ERS_WAIT(ERS_WAIT)
  ) u_seq (
    .clk(clk), .rst(rst), .vpp_hi(vpp_hi), .wr_stb(wr_stb),
    .wr_addr(wr_addr), .wr_data(wr_data), .host_addr(addr),
    .mem_q(mem_q), .mode(mode), .busy(busy), .erasing(erasing),
    .pgm_msb(pgm_msb), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wd(mem_wd)
  );

  fci_array #(.ADDR_W(ADDR_W)) u_mem (
    .clk(clk), .we(mem_we), .a(mem_addr), .wd(mem_wd), .q(mem_q)
  );

  fci_readmux u_rd (
    .clk(clk), .rst(rst), .rd_live(rd_live), .rd_first(rd_first),
    .mode(mode), .busy(busy), .erasing(erasing), .pgm_msb(pgm_msb),
    .id_sel(addr[0]), .mem_q(mem_q), .dq_o(dq_o), .dq_oe(dq_oe),
    .tgl(tgl)
  );

endmodule

// File: rtl/fci_checker.sv
module fci_checker
  import flash_cmd_pkg::*;
(
  input logic  clk,
  input logic  rst,
  input logic  vpp_hi,
  input logic  ce_n,
  input logic  oe_n,
  input logic  we_n,
  input logic  dq_oe,
  input mode_t mode,
  input logic  busy,
  input logic  mem_we,
  input logic  rd_first,
  input logic  tgl
);

  // R2: low supply pulls the command state back to array read
  assert_vpp_forces_read_R2: assert property (@(posedge clk) disable iff (rst)
    !vpp_hi |=> (mode == M_READ));

  // R2: the array is never written without the supply
  assert_no_write_without_vpp_R2: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> vpp_hi);

  // R1: output drive only follows a read cycle on the strobes
  assert_oe_from_read_cycle_R1: assert property (@(posedge clk) disable iff (rst)
    dq_oe |-> $past(!ce_n && !oe_n && we_n, 2));

  // R6: each new read cycle during an operation flips the toggle bit
  assert_toggle_flips_R6: assert property (@(posedge clk) disable iff (rst)
    (busy && rd_first) |=> (tgl != $past(tgl)));

  // R5: the end of an operation lands in array read
  assert_done_to_read_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (mode == M_READ));

endmodule

bind flash_cmd_if fci_checker u_chk (
  .clk(clk), .rst(rst), .vpp_hi(vpp_hi), .ce_n(ce_n), .oe_n(oe_n),
  .we_n(we_n), .dq_oe(dq_oe), .mode(mode), .busy(busy),
  .mem_we(mem_we), .rd_first(rd_first), .tgl(tgl)
);

// File: tb/flash_cmd_if_test.sv
`timescale 1ns/1ps
module flash_cmd_if_test;

  localparam int AW    = 6;
  localparam int BAW   = 4;
  localparam int PGMC  = 24;
  localparam int EWAIT = 12;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          vpp_hi = 1'b1;
  logic          ce_n = 1'b1;
  logic          oe_n = 1'b1;
  logic          we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0]    dq_i = '0;
  logic [7:0]    dq_o;
  logic          dq_oe;

  int total = 0;
  int bad   = 0;
  logic [7:0] model [DEPTH];

  always #2.5 clk = ~clk;

  flash_cmd_if #(.ADDR_W(AW), .BLK_AW(BAW), .PGM_CYCLES(PGMC), .ERS_WAIT(EWAIT)) uut (
    .clk(clk), .rst(rst), .vpp_hi(vpp_hi), .ce_n(ce_n), .oe_n(oe_n),
    .we_n(we_n), .addr(addr), .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe)
  );

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk); addr = AW'(a); dq_i = d; ce_n = 1'b0; we_n = 1'b0;
    repeat (2) @(negedge clk);
    we_n = 1'b1;
    @(negedge clk); ce_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic rd(input int a, input int hold, output logic [7:0] v);
    @(negedge clk); addr = AW'(a); ce_n = 1'b0; oe_n = 1'b0;
    repeat (hold) @(negedge clk);
    v = dq_o;
    oe_n = 1'b1; ce_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic check_all(input string tag);
    logic [7:0] v;
    for (int i = 0; i < DEPTH; i++) begin
      rd(i, 4, v);
      check(tag, v, model[i]);
    end
  endtask

  task automatic pgm(input int a, input logic [7:0] d);
    wr(0, 8'h40);
    wr(a, d);
    model[a] = model[a] & d;
    repeat (PGMC + 8) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v, v2, d;
    for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    check("R1 oe idle", {7'b0, dq_oe}, 8'h00);
    check_all("R1 erased at start");

    // R4: identifier codes, high address bits ignored
    wr(0, 8'h90);
    rd(0, 4, v);  check("R4 maker", v, 8'hC2);
    rd(1, 4, v);  check("R4 part", v, 8'h3C);
    rd(6, 4, v);  check("R4 maker hi addr", v, 8'hC2);
    rd(7, 4, v);  check("R4 part hi addr", v, 8'h3C);

    // R3: array read persists
    wr(0, 8'h00);
    rd(0, 4, v);  check("R3 array", v, model[0]);
    rd(1, 4, v);  check("R3 array again", v, model[1]);

    // R5: program sweep over every address
    for (int a = 0; a < DEPTH; a++) begin
      d = 8'(a * 29 + 7);
      if (d == 8'hFF) d = 8'hFE;
      pgm(a, d);
    end
    check_all("R5 program sweep");
    pgm(5, 8'h0F);
    pgm(5, 8'hF3);
    rd(5, 4, v);  check("R5 and of two programs", v, model[5]);

    // R6: status during a program
    wr(0, 8'h40);
    wr(12, 8'h3C);
    model[12] = model[12] & 8'h3C;
    rd(12, 4, v);
    check("R6 polling bit", {7'b0, v[7]}, 8'h01);
    check("R6 low bits", {2'b0, v[5:0]}, 8'h00);
    rd(12, 4, v2);
    check("R6 toggle", {7'b0, v[6] ^ v2[6]}, 8'h01);
    repeat (PGMC + 8) @(negedge clk);
    rd(12, 4, v); check("R6 data after", v, model[12]);

    // R7: chip erase
    wr(0, 8'h30);
    wr(0, 8'h30);
    rd(0, 4, v);
    check("R7 erase status", {v[7], 1'b0, v[5:0]}, 8'h00);
    repeat (2 * DEPTH + EWAIT + 40) @(negedge clk);
    for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
    check_all("R7 chip erased");

    // R8: block erase touches only the addressed block
    pgm(3, 8'h00);
    pgm(20, 8'h00);
    pgm(40, 8'h00);
    pgm(17, 8'h5A);
    wr(0, 8'h20);
    wr(21, 8'hD0);
    repeat (2 * (1 << BAW) + EWAIT + 40) @(negedge clk);
    for (int i = 16; i < 32; i++) model[i] = 8'hFF;
    rd(20, 4, v); check("R8 target erased", v, 8'hFF);
    rd(3, 4, v);  check("R8 block0 kept", v, 8'h00);
    rd(40, 4, v); check("R8 block2 kept", v, 8'h00);
    check_all("R8 block erase map");

    // R9: double FFh abort after each set-up
    wr(0, 8'h40); wr(3, 8'hFF); wr(3, 8'hFF);
    rd(3, 4, v);  check("R9 pgm abort mem", v, model[3]);
    wr(0, 8'h30); wr(0, 8'hFF); wr(0, 8'hFF);
    repeat (2 * DEPTH) @(negedge clk);
    rd(40, 4, v); check("R9 chip abort mem", v, model[40]);
    wr(0, 8'h20); wr(3, 8'hFF); wr(3, 8'hFF);
    repeat (40) @(negedge clk);
    rd(3, 4, v);  check("R9 blk abort mem", v, model[3]);
    check_all("R9 nothing altered");

    // R10: unrecognised confirm returns to read
    wr(0, 8'h30); wr(0, 8'h55);
    rd(3, 4, v);  check("R10 after bad chip confirm", v, model[3]);
    wr(0, 8'h20); wr(40, 8'h30);
    repeat (40) @(negedge clk);
    rd(40, 4, v); check("R10 after bad blk confirm", v, model[40]);

    // R11: address from the start, data from the end of the cycle
    wr(0, 8'h40);
    @(negedge clk); addr = AW'(33); dq_i = 8'hF0; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk); addr = AW'(34);
    @(negedge clk); dq_i = 8'h0F;
    @(negedge clk); we_n = 1'b1;
    @(negedge clk); ce_n = 1'b1;
    model[33] = model[33] & 8'h0F;
    repeat (PGMC + 8) @(negedge clk);
    rd(33, 4, v); check("R11 first address", v, model[33]);
    rd(34, 4, v); check("R11 other address", v, model[34]);

    // R2: supply low
    vpp_hi = 1'b0;
    wr(0, 8'h90);
    rd(0, 4, v);  check("R2 no ident", v, model[0]);
    wr(0, 8'h40); wr(2, 8'h00);
    repeat (PGMC + 8) @(negedge clk);
    rd(2, 4, v);  check("R2 no program", v, model[2]);
    vpp_hi = 1'b1;
    wr(0, 8'h90);
    vpp_hi = 1'b0;
    repeat (2) @(negedge clk);
    rd(1, 4, v);  check("R2 ident dropped", v, model[1]);
    vpp_hi = 1'b1;

    // R12: writes during a program are ignored
    wr(0, 8'h40);
    wr(50, 8'h0F);
    model[50] = model[50] & 8'h0F;
    wr(0, 8'h90);
    repeat (PGMC + 8) @(negedge clk);
    rd(0, 4, v);  check("R12 no ident", v, model[0]);
    rd(50, 4, v); check("R12 programmed", v, model[50]);

    // R5 and R6: read started at every offset around completion
    for (int off = 0; off < 8; off++) begin
      wr(0, 8'h40);
      wr(56 + off, 8'(8'h11 << (off % 4)));
      model[56 + off] = model[56 + off] & 8'(8'h11 << (off % 4));
      repeat (PGMC - 6 + off) @(negedge clk);
      rd(56 + off, 30, v);
      check("R5 read across completion", v, model[56 + off]);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule